// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer

This block is a clock-accurate model of the digital control around an 8-bit sampling converter. A single active-low start line serves two purposes. Its falling edge starts a conversion. Its level, sampled when the end-of-conversion pulse finishes, decides whether the converter stays powered or powers down on its own. A separate active-low power-down line forces the converter off. A rising edge on that line brings it back up.

While a conversion runs, the track/hold output shows the hold window and then returns to track before the result is ready. The result is taken from a converter stub at the moment the end-of-conversion strobe drops, and it is held until the next conversion completes. Reads are done with an active-low read strobe. Its falling edge latches the channel address for the next conversion, and its rising edge cuts the strobe short. Every duration is a parameter in clock cycles. A parameter selects which power-up count applies, external or internal reference. A start edge that arrives while the converter is powering up is treated in one of two ways, depending on that choice:
- With the external reference, the edge is remembered and the conversion starts when power-up completes.
- With the internal reference, the edge is dropped and reported on an error pulse.

Top module: `adc_conv_seq`

## Requirements
- R1: When powered and idle, a falling edge on `conv_start_n` starts a conversion. `hold` is high right after the clock edge that first sees the low level.
- R2: `hold` stays high for exactly TRACK_CYC cycles and then returns low while the conversion is still running.
- R3: `eoc_n` goes low CONV_CYC cycles after the clock edge that started the conversion. At that same edge `result` takes the value of `conv_data`, and it keeps that value until the next conversion completes.
- R4: `eoc_n` stays low for EOC_CYC cycles and then returns high. A rising edge on `rd_n` while `eoc_n` is low drives `eoc_n` high at the next clock edge.
- R5: At the edge where `eoc_n` returns high, the level of `conv_start_n` is sampled. Low means `powered` drops to 0. High means `powered` stays 1.
- R6: After a power-down caused by `conv_start_n`, a rising edge on `conv_start_n` starts power-up. `powered` becomes 1 after the power-up count: PU_EXT_CYC when USE_INT_REF is 0, PU_INT_CYC when it is 1. The count is taken from the edge that sees the rise.
- R7: With the external reference, a falling edge of `conv_start_n` during power-up is deferred. `hold` is high in the same cycle that `powered` first reads 1, and the conversion then completes as in R3.
- R8: With the internal reference, a falling edge of `conv_start_n` during power-up starts nothing. It raises `start_err` for exactly one cycle. `start_err` stays 0 with the external reference.
- R9: After reset the outputs are: `powered`=0, `eoc_n`=1, `hold`=0, `chan_sel`=0 (channel 1), `result`=0. In this state only a rising edge of `pwr_dn_n` starts power-up, and edges on `conv_start_n` have no effect.
- R10: `pwr_dn_n` low forces the block off within one clock edge from any state, including mid-conversion: `powered`=0, `hold`=0, `eoc_n`=1. A later rising edge of `pwr_dn_n` powers the block up after the selected power-up count.
- R11: A falling edge of `rd_n` while powered loads `chan_addr` into `chan_sel`, where address value n selects channel n+1. While unpowered, read strobes leave `chan_sel` unchanged, and the selection survives power-down.
- R12: Falling edges of `conv_start_n` during a running conversion are ignored. Timing and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, models supply turn-on |
| conv_start_n | input | 1 | Active-low convert start, also the power-down request level |
| pwr_dn_n | input | 1 | Active-low forced power-down |
| rd_n | input | 1 | Active-low read strobe |
| chan_addr | input | CH_W (3) | Channel address for the next conversion |
| conv_data | input | DATA_W (8) | Result from the converter stub |
| eoc_n | output | 1 | Active-low end-of-conversion pulse |
| hold | output | 1 | Track/hold in hold |
| powered | output | 1 | Converter fully powered |
| start_err | output | 1 | One-cycle flag for a start edge dropped during power-up |
| chan_sel | output | CH_W (3) | Latched channel index |
| result | output | DATA_W (8) | Held conversion result |

## Verification
The in-line properties are checked on every cycle. They cover these rules:
- The strobe is only ever low while powered.
- Neither the hold window nor the strobe outlasts its parameter.
- `hold` rises only at the first cycle of a conversion.
- A strobe that ends with the start line low always leaves the block unpowered.
- The error flag only follows a power-up cycle.
- The channel register never moves while unpowered.

Exact cycle positions need the bench's scenarios. These include strobe placement, the early end on a read, the deferred start that lands on the power-up boundary, the result capture and its hold, and the difference between the two reference choices.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_OFF_PIN = 3'd0,
        S_OFF_CS  = 3'd1,
        S_WAKE    = 3'd2,
        S_IDLE    = 3'd3,
        S_CONV    = 3'd4,
        S_EOC     = 3'd5
    } seq_state_e;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_seq_edges.sv
module adc_seq_edges #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign fall[i] = prev_q[i] & ~lvl[i];
        assign rise[i] = ~prev_q[i] & lvl[i];
    end
endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            powered,
    input  logic            rd_fall,
    input  logic [CH_W-1:0] addr,
    output logic [CH_W-1:0] chan
);
    logic [CH_W-1:0] chan_d, chan_q;

    always_comb begin
        chan_d = chan_q;
        if (powered && rd_fall) chan_d = addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign chan = chan_q;

    // R11: selection frozen while unpowered
    p_chan_frozen_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!powered && !$past(powered)) |-> $stable(chan_q))
        else $error("channel changed while unpowered");
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CONV_CYC  = 21,
    parameter int TRACK_CYC = 6,
    parameter int EOC_CYC   = 5,
    parameter int PU_CYC    = 50,
    parameter bit DEFER_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              pd_lvl,
    input  logic              pd_rise,
    input  logic              rd_rise,
    input  logic [DATA_W-1:0] data_in,
    output logic              eoc_n,
    output logic              hold,
    output logic              powered,
    output logic              start_err,
    output logic [DATA_W-1:0] result
);
    localparam int unsigned CNT_MAX = max3(CONV_CYC, EOC_CYC, PU_CYC);
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] EOC_LAST  = CNT_W'(EOC_CYC - 1);
    localparam logic [CNT_W-1:0] PU_LAST   = CNT_W'(PU_CYC - 1);
    localparam logic [CNT_W-1:0] TRACK_LIM = CNT_W'(TRACK_CYC);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              pending;
        logic              hold;
        logic              eoc_n;
        logic              err;
        logic [DATA_W-1:0] result;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        unique case (r_q.state)
            S_OFF_PIN: begin
                if (pd_rise) begin
                    r_d.state   = S_WAKE;
                    r_d.cnt     = '0;
                    r_d.pending = 1'b0;
                end
            end
            S_OFF_CS: begin
                if (cs_rise) begin
                    r_d.state   = S_WAKE;
                    r_d.cnt     = '0;
                    r_d.pending = 1'b0;
                end
            end
            S_WAKE: begin
                if (cs_fall) begin
                    if (DEFER_EN) r_d.pending = 1'b1;
                    else          r_d.err     = 1'b1;
                end
                if (r_q.cnt == PU_LAST) begin
                    r_d.cnt     = '0;
                    r_d.pending = 1'b0;
                    if (r_q.pending || (cs_fall && DEFER_EN)) begin
                        r_d.state = S_CONV;
                        r_d.hold  = 1'b1;
                    end else begin
                        r_d.state = S_IDLE;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_IDLE: begin
                if (cs_fall) begin
                    r_d.state = S_CONV;
                    r_d.cnt   = '0;
                    r_d.hold  = 1'b1;
                end
            end
            S_CONV: begin
                if (r_q.cnt == CONV_LAST) begin
                    r_d.state  = S_EOC;
                    r_d.cnt    = '0;
                    r_d.hold   = 1'b0;
                    r_d.eoc_n  = 1'b0;
                    r_d.result = data_in;
                end else begin
                    r_d.cnt  = r_q.cnt + 1'b1;
                    r_d.hold = (r_q.cnt + 1'b1) < TRACK_LIM;
                end
            end
            S_EOC: begin
                if (rd_rise || (r_q.cnt == EOC_LAST)) begin
                    r_d.eoc_n = 1'b1;
                    r_d.cnt   = '0;
                    r_d.state = cs_lvl ? S_IDLE : S_OFF_CS;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = S_OFF_PIN;
        endcase

        if (!pd_lvl) begin
            r_d.state   = S_OFF_PIN;
            r_d.cnt     = '0;
            r_d.pending = 1'b0;
            r_d.hold    = 1'b0;
            r_d.eoc_n   = 1'b1;
            r_d.err     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= S_OFF_PIN;
            r_q.cnt     <= '0;
            r_q.pending <= 1'b0;
            r_q.hold    <= 1'b0;
            r_q.eoc_n   <= 1'b1;
            r_q.err     <= 1'b0;
            r_q.result  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign eoc_n     = r_q.eoc_n;
    assign hold      = r_q.hold;
    assign start_err = r_q.err;
    assign result    = r_q.result;
    assign powered   = (r_q.state == S_IDLE) || (r_q.state == S_CONV) || (r_q.state == S_EOC);

    logic [15:0] low_run_q, hold_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q  <= '0;
            hold_run_q <= '0;
        end else begin
            low_run_q  <= r_q.eoc_n ? 16'd0 : low_run_q + 16'd1;
            hold_run_q <= r_q.hold ? hold_run_q + 16'd1 : 16'd0;
        end
    end

    p_hold_starts_conv_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.hold) |-> (r_q.state == S_CONV && r_q.cnt == '0))
        else $error("hold rose outside a conversion start");

    p_hold_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.hold |-> (hold_run_q < 16'(TRACK_CYC)))
        else $error("hold window too long");

    p_eoc_powered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.eoc_n |-> powered)
        else $error("strobe low while unpowered");

    p_eoc_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.eoc_n |-> (low_run_q < 16'(EOC_CYC)))
        else $error("strobe too long");

    p_auto_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(r_q.eoc_n) && !$past(cs_lvl)) |-> !powered)
        else $error("stayed powered with start line low");

    p_err_after_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |-> $past(r_q.state == S_WAKE))
        else $error("error flag outside power-up");
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int DATA_W      = 8,
    parameter int CH_W        = 3,
    parameter int CONV_CYC    = 21,
    parameter int TRACK_CYC   = 6,
    parameter int EOC_CYC     = 5,
    parameter int PU_EXT_CYC  = 50,
    parameter int PU_INT_CYC  = 1250,
    parameter bit USE_INT_REF = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start_n,
    input  logic              pwr_dn_n,
    input  logic              rd_n,
    input  logic [CH_W-1:0]   chan_addr,
    input  logic [DATA_W-1:0] conv_data,
    output logic              eoc_n,
    output logic              hold,
    output logic              powered,
    output logic              start_err,
    output logic [CH_W-1:0]   chan_sel,
    output logic [DATA_W-1:0] result
);
    localparam int PU_CYC = USE_INT_REF ? PU_INT_CYC : PU_EXT_CYC;
    localparam int IDX_CS = 0;
    localparam int IDX_PD = 1;
    localparam int IDX_RD = 2;

    logic [2:0] lines, fall, rise;
    logic       pd_fall_unused;

    assign lines = {rd_n, pwr_dn_n, conv_start_n};
    assign pd_fall_unused = fall[IDX_PD];

    adc_seq_edges #(.N(3)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lines),
        .fall (fall),
        .rise (rise)
    );

    adc_seq_fsm #(
        .DATA_W   (DATA_W),
        .CONV_CYC (CONV_CYC),
        .TRACK_CYC(TRACK_CYC),
        .EOC_CYC  (EOC_CYC),
        .PU_CYC   (PU_CYC),
        .DEFER_EN (!USE_INT_REF)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_lvl   (conv_start_n),
        .cs_fall  (fall[IDX_CS]),
        .cs_rise  (rise[IDX_CS]),
        .pd_lvl   (pwr_dn_n),
        .pd_rise  (rise[IDX_PD]),
        .rd_rise  (rise[IDX_RD]),
        .data_in  (conv_data),
        .eoc_n    (eoc_n),
        .hold     (hold),
        .powered  (powered),
        .start_err(start_err),
        .result   (result)
    );

    adc_seq_chan #(.CH_W(CH_W)) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .powered(powered),
        .rd_fall(fall[IDX_RD]),
        .addr   (chan_addr),
        .chan   (chan_sel)
    );
endmodule

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;
    localparam int C  = 21;
    localparam int T  = 6;
    localparam int E  = 5;
    localparam int PU = 50;

    logic       clk = 1'b0;
    logic       rst_n, cs_n, pd_n, rd_n;
    logic [2:0] addr;
    logic [7:0] data;
    logic       eoc_n, hold, powered, err;
    logic [2:0] chan;
    logic [7:0] res;
    logic       i_eoc_n, i_hold, i_powered, i_err;
    logic [2:0] i_chan;
    logic [7:0] i_res;

    int checks = 0;
    int fails  = 0;
    logic [2:0] exp_chan = 3'd0;

    always #10 clk = ~clk;

    adc_conv_seq #(.CONV_CYC(C), .TRACK_CYC(T), .EOC_CYC(E), .PU_EXT_CYC(PU),
                   .PU_INT_CYC(1250), .USE_INT_REF(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_start_n(cs_n), .pwr_dn_n(pd_n), .rd_n(rd_n),
        .chan_addr(addr), .conv_data(data), .eoc_n(eoc_n), .hold(hold),
        .powered(powered), .start_err(err), .chan_sel(chan), .result(res));

    adc_conv_seq #(.CONV_CYC(C), .TRACK_CYC(T), .EOC_CYC(E), .PU_EXT_CYC(9),
                   .PU_INT_CYC(PU), .USE_INT_REF(1'b1)) u_dut_int (
        .clk(clk), .rst_n(rst_n), .conv_start_n(cs_n), .pwr_dn_n(pd_n), .rd_n(rd_n),
        .chan_addr(addr), .conv_data(data), .eoc_n(i_eoc_n), .hold(i_hold),
        .powered(i_powered), .start_err(i_err), .chan_sel(i_chan), .result(i_res));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_hold(int k);
        return (k >= 1) && (k <= T);
    endfunction

    function automatic bit exp_eoc_n(int k, int x);
        return !((k >= C + 1) && (k < x));
    endfunction

    function automatic bit exp_pw(int k, int x, bit pdm);
        return pdm ? (k < x) : 1'b1;
    endfunction

    task automatic do_conv(logic [7:0] d, bit pdm, bit early, int j, logic [2:0] raddr, bit glitch);
        int x;
        x = early ? C + 2 + j : C + 1 + E;
        data = d;
        cs_n = 1'b0;
        for (int k = 1; k <= x + 1; k++) begin
            @(negedge clk);
            chk("R1/R2 hold", hold, exp_hold(k));
            chk("R3/R4 eoc_n", eoc_n, exp_eoc_n(k, x));
            chk("R5 powered", powered, exp_pw(k, x, pdm));
            if (k >= C + 1) chk("R3 result", res, d);
            if (glitch && k >= C + 1 && k <= C + 2) chk("R12 result", res, d);
            if (k == 1 && !pdm) cs_n = 1'b1;
            if (glitch && k == 3) cs_n = 1'b0;
            if (glitch && k == 4) cs_n = 1'b1;
            if (k == C + 2) data = ~d;
            if (early && k == C + 1) begin rd_n = 1'b0; addr = raddr; exp_chan = raddr; end
            if (early && k == C + 1 + j) rd_n = 1'b1;
        end
        chk("R11 chan", chan, exp_chan);
        chk("R3 result held", res, d);
    endtask

    task automatic do_wake(bit pend);
        cs_n = 1'b1;
        for (int k = 1; k <= PU + 1; k++) begin
            @(negedge clk);
            chk("R6 powered", powered, k >= PU + 1);
            chk("R8 ext err", err, 0);
            if (pend && k == 4) chk("R8 int err", i_err, 1);
            if (pend && k == 5) chk("R8 int err clear", i_err, 0);
            if (pend && k == 3) cs_n = 1'b0;
            if (pend && k == 5) cs_n = 1'b1;
        end
        chk("R11 chan kept", chan, exp_chan);
        if (pend) begin
            chk("R7 deferred hold", hold, 1);
            chk("R8 int no hold", i_hold, 0);
            chk("R8 int powered", i_powered, 1);
            for (int k = PU + 2; k <= PU + 2 + C + E; k++) begin
                @(negedge clk);
                if (k == PU + 1 + C) chk("R7 deferred eoc", eoc_n, 0);
                if (k == PU + C) chk("R7 eoc not early", eoc_n, 1);
            end
            chk("R7 eoc done", eoc_n, 1);
            chk("R7 powered", powered, 1);
        end
    endtask

    task automatic rd_pulse(logic [2:0] a);
        addr = a;
        rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit pdm, early, glitch;
        int j;
        logic [2:0] ra;
        logic [7:0] dv;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; cs_n = 1'b1; pd_n = 1'b1; rd_n = 1'b1; addr = 3'd0; data = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 powered", powered, 0);
        chk("R9 eoc_n", eoc_n, 1);
        chk("R9 hold", hold, 0);
        chk("R9 chan", chan, 0);
        chk("R9 result", res, 0);

        // R9: start line edges do nothing after reset
        cs_n = 1'b0; @(negedge clk); cs_n = 1'b1;
        repeat (PU + 5) @(negedge clk);
        chk("R9 no wake on start", powered, 0);
        chk("R9 no hold", hold, 0);
        rd_pulse(3'd5);
        chk("R11 ignored off", chan, 0);

        // R10: power-down pin rising edge wakes
        pd_n = 1'b0; @(negedge clk); pd_n = 1'b1;
        for (int k = 1; k <= PU + 1; k++) begin
            @(negedge clk);
            if (k == PU) chk("R10 not yet", powered, 0);
        end
        chk("R10 wake", powered, 1);
        chk("R10 int wake", i_powered, 1);

        rd_pulse(3'd3); exp_chan = 3'd3;
        chk("R11 latch", chan, 3);

        do_conv(8'hA5, 0, 0, 1, 3'd0, 0);
        do_conv(8'h3C, 0, 1, 2, 3'd6, 0);
        do_conv(8'h81, 0, 0, 1, 3'd0, 1);
        do_conv(8'h5A, 1, 0, 1, 3'd0, 0);
        rd_pulse(3'd1);
        chk("R11 off read ignored", chan, exp_chan);
        do_wake(0);
        do_conv(8'hF0, 1, 1, 1, 3'd7, 0);
        do_wake(1);

        // R10: forced power-down mid conversion
        cs_n = 1'b0;
        for (int k = 1; k <= 7 + PU; k++) begin
            @(negedge clk);
            if (k == 1) cs_n = 1'b1;
            if (k == 5) pd_n = 1'b0;
            if (k == 6) begin
                chk("R10 off", powered, 0);
                chk("R10 hold", hold, 0);
                chk("R10 eoc_n", eoc_n, 1);
                pd_n = 1'b1;
            end
            if (k == 6 + PU) chk("R10 still waking", powered, 0);
        end
        chk("R10 rewake", powered, 1);
        chk("R11 chan survives", chan, exp_chan);

        for (int i = 0; i < 10; i++) begin
            dv = 8'($urandom);
            pdm = ($urandom % 3) == 0;
            early = $urandom % 2;
            j = 1 + int'($urandom % (E - 1));
            ra = 3'($urandom);
            glitch = !pdm && ($urandom % 2 == 1);
            do_conv(dv, pdm, early, j, ra, glitch);
            if (pdm) do_wake(0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule